// File: doc/BRIEF.md
# Eight-Channel Switch Command and Fault Latch

This block is the digital control core of an eight-channel load switch. It produces one gate-enable per channel. Each enable combines a register-held command with two external control pins. Each pin reaches the channels through its own routing mask, so one pin may drive any set of outputs. Each channel has a fault latch. An overcurrent or over-temperature event pulse sets the latch and forces the channel off. Only a write-one-to-clear register write releases the latch.

When the limp home input is high, a latched channel can recover by itself. This happens when a pin routed to it is high and a programmable number of cycles has passed. Each channel keeps its own restart counter for this. While the sleep input is low, the block bypasses all register and fault state. Pin 0 then drives channel 2 and pin 1 drives channel 3, and every other channel is held off.

Registers are written through a simple parallel write port. They are read back, together with the fault latch word, through a combinational read port.

Top module: `swc_core`

## Requirements
- R1: After synchronous reset the command register reads 0x00, the pin 0 mask 0x04, the pin 1 mask 0x08, the restart register 0x10 and the fault word 0x00, and all gates are off.
- R2: With sleep_n high, gate bit i = (cmd[i] OR (in0 AND mask0[i]) OR (in1 AND mask1[i])) AND NOT fault[i]. Pin changes reach the gates in the same cycle. Register writes (cmd at address 0) take effect after the next clock edge.
- R3: Each mask register (pin 0 at address 1, pin 1 at address 2) may select any set of channels, including several channels at once and none.
- R4: With sleep_n low, gate[2] equals in0, gate[3] equals in1, and all other gates are 0, whatever the registers and fault latches hold.
- R5: An oc_evt or ot_evt bit high at a clock edge sets that channel's fault latch at that edge, which turns its gate off.
- R6: Writing to address 3 clears each fault latch whose data bit is 1. Bits written as 0 leave their latch unchanged. A clear is ignored for any channel whose event input is still high in that cycle.
- R7: With limp high, a latched channel whose pin request is high clears itself after the restart count of consecutive qualifying cycles. A cycle with the pin request low, or with limp low, restarts the count from zero.
- R8: Reading address 6 returns the eight fault latches, bit i for channel i. Reading address 4 returns the restart count. Reading any unused address returns 0.
- R9: A restart count of 0 behaves like a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational read data |
| in0 | input | 1 | Control pin 0 |
| in1 | input | 1 | Control pin 1 |
| sleep_n | input | 1 | Low selects the sleep bypass path |
| limp | input | 1 | Limp home mode enable |
| oc_evt | input | 8 | Per-channel overcurrent event |
| ot_evt | input | 8 | Per-channel over-temperature event |
| gate | output | 8 | Per-channel gate enable |
| fault | output | 8 | Per-channel fault latch status |

## Verification
Pin and sleep changes reach the gates in the same cycle. Register writes and event pulses act at the next clock edge. A limp home restart lands exactly on the restart-count-th edge after the latch is set. The bench drives every input on the falling edge. It samples one falling edge after the edge where a result is due, and checks the restart both one cycle before and on the due cycle.

// File: rtl/swc_pkg.sv
package swc_pkg;
    localparam int NUM_CH  = 8;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = NUM_CH;
    localparam int RT_W    = DATA_W;

    typedef logic [NUM_CH-1:0] ch_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CMD   = 3'd0,
        ADR_MASK0 = 3'd1,
        ADR_MASK1 = 3'd2,
        ADR_CLR   = 3'd3,
        ADR_RTIME = 3'd4,
        ADR_DIAG  = 3'd6
    } reg_addr_e;

    localparam ch_vec_t          MASK0_RST = ch_vec_t'(8'h04);
    localparam ch_vec_t          MASK1_RST = ch_vec_t'(8'h08);
    localparam logic [RT_W-1:0]  RTIME_RST = RT_W'(16);

    typedef struct packed {
        ch_vec_t          cmd;
        ch_vec_t          mask0;
        ch_vec_t          mask1;
        logic [RT_W-1:0]  rtime;
    } ctrl_regs_t;

    function automatic ch_vec_t pin_request(input ctrl_regs_t r, input logic p0, input logic p1);
        return (r.mask0 & {NUM_CH{p0}}) | (r.mask1 & {NUM_CH{p1}});
    endfunction
endpackage

// File: rtl/swc_regs.sv
module swc_regs
    import swc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  ch_vec_t           fault_q,
    output ctrl_regs_t        regs,
    output ch_vec_t           clr_req,
    output logic [DATA_W-1:0] rd_data
);
    ctrl_regs_t regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.cmd   <= '0;
            regs_q.mask0 <= MASK0_RST;
            regs_q.mask1 <= MASK1_RST;
            regs_q.rtime <= RTIME_RST;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_CMD:   regs_q.cmd   <= wr_data;
                ADR_MASK0: regs_q.mask0 <= wr_data;
                ADR_MASK1: regs_q.mask1 <= wr_data;
                ADR_RTIME: regs_q.rtime <= wr_data;
                default:   ;
            endcase
        end
    end

    assign regs    = regs_q;
    assign clr_req = (wr_en && wr_addr == ADR_CLR) ? wr_data : '0;

    always_comb begin
        case (rd_addr)
            ADR_CMD:   rd_data = regs_q.cmd;
            ADR_MASK0: rd_data = regs_q.mask0;
            ADR_MASK1: rd_data = regs_q.mask1;
            ADR_RTIME: rd_data = regs_q.rtime;
            ADR_DIAG:  rd_data = fault_q;
            default:   rd_data = '0;
        endcase
    end

    // R1: reset restores the default routing masks
    a_r1_reset_masks: assert property (@(posedge clk)
        rst |=> (regs_q.mask0 == MASK0_RST && regs_q.mask1 == MASK1_RST));
endmodule

// File: rtl/swc_fault_ch.sv
module swc_fault_ch
    import swc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            evt,
    input  logic            clr,
    input  logic            limp,
    input  logic            pin_req,
    input  logic [RT_W-1:0] rtime,
    output logic            fault_q
);
    logic [RT_W-1:0] cnt_q;
    logic            qualify;
    logic            expire;
    logic [RT_W:0]   cnt_next;

    assign qualify  = limp && fault_q && pin_req;
    assign cnt_next = {1'b0, cnt_q} + 1'b1;
    assign expire   = qualify && (cnt_next >= {1'b0, rtime});

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (evt)
                fault_q <= 1'b1;
            else if (clr || expire)
                fault_q <= 1'b0;

            if (!qualify || expire)
                cnt_q <= '0;
            else
                cnt_q <= cnt_next[RT_W-1:0];
        end
    end

    // R5: an event latches the fault at that edge
    a_r5_event_latches: assert property (@(posedge clk) disable iff (rst)
        evt |=> fault_q);
    // R6: a clear coinciding with an active event is ignored
    a_r6_clear_blocked: assert property (@(posedge clk) disable iff (rst)
        (evt && clr) |=> fault_q);
    // R7: leaving limp home restarts the count
    a_r7_limp_exit_resets: assert property (@(posedge clk) disable iff (rst)
        !limp |=> (cnt_q == '0));
    // R7: no recovery outside limp home without a clear
    a_r7_no_self_clear: assert property (@(posedge clk) disable iff (rst)
        (fault_q && !limp && !clr) |=> fault_q);
endmodule

// File: rtl/swc_gate_mux.sv
module swc_gate_mux
    import swc_pkg::*;
(
    input  ctrl_regs_t regs,
    input  ch_vec_t    fault_q,
    input  logic       in0,
    input  logic       in1,
    input  logic       sleep_n,
    output ch_vec_t    pin_req,
    output ch_vec_t    gate
);
    ch_vec_t awake_cmd;
    ch_vec_t bypass_cmd;

    assign pin_req   = pin_request(regs, in0, in1);
    assign awake_cmd = (regs.cmd | pin_req) & ~fault_q;

    always_comb begin
        bypass_cmd    = '0;
        bypass_cmd[2] = in0;
        bypass_cmd[3] = in1;
    end

    assign gate = sleep_n ? awake_cmd : bypass_cmd;

    // R4: sleep path touches only channels 2 and 3
    always_comb begin
        if (!sleep_n)
            a_r4_sleep_only_two: assert ($countones(gate & ~ch_vec_t'(8'h0C)) == 0);
    end
endmodule

// File: rtl/swc_core.sv
module swc_core
    import swc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       in0,
    input  logic       in1,
    input  logic       sleep_n,
    input  logic       limp,
    input  logic [7:0] oc_evt,
    input  logic [7:0] ot_evt,
    output logic [7:0] gate,
    output logic [7:0] fault
);
    ctrl_regs_t regs;
    ch_vec_t    clr_req;
    ch_vec_t    fault_q;
    ch_vec_t    pin_req;

    swc_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .fault_q(fault_q), .regs(regs), .clr_req(clr_req),
        .rd_data(rd_data)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        swc_fault_ch u_ch (
            .clk(clk), .rst(rst), .evt(oc_evt[i] | ot_evt[i]), .clr(clr_req[i]),
            .limp(limp), .pin_req(pin_req[i]), .rtime(regs.rtime), .fault_q(fault_q[i])
        );
    end

    swc_gate_mux u_mux (
        .regs(regs), .fault_q(fault_q), .in0(in0), .in1(in1), .sleep_n(sleep_n),
        .pin_req(pin_req), .gate(gate)
    );

    assign fault = fault_q;

    // R2: while awake a latched channel never drives its gate
    a_r2_fault_blocks_gate: assert property (@(posedge clk) disable iff (rst)
        sleep_n |-> ((gate & fault) == '0));
endmodule

// File: tb/test_swc_core.sv
module test_swc_core;
    logic       clk = 0;
    logic       rst = 1;
    logic       wr_en = 0;
    logic [2:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic [2:0] rd_addr = 0;
    logic [7:0] rd_data;
    logic       in0 = 0, in1 = 0, sleep_n = 1, limp = 0;
    logic [7:0] oc_evt = 0, ot_evt = 0;
    logic [7:0] gate, fault;
    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    swc_core i_swc_core (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .in0(in0), .in1(in1), .sleep_n(sleep_n),
        .limp(limp), .oc_evt(oc_evt), .ot_evt(ot_evt), .gate(gate), .fault(fault)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(3'd0, d); chk("R1 cmd", d, 8'h00);
        rd(3'd1, d); chk("R1 mask0", d, 8'h04);
        rd(3'd2, d); chk("R1 mask1", d, 8'h08);
        rd(3'd4, d); chk("R1 rtime", d, 8'h10);
        rd(3'd6, d); chk("R1/R8 diag", d, 8'h00);
        chk("R1 gates", gate, 8'h00);
    endtask

    task automatic t_default_map;
        in0 = 1; #1 chk("R2 in0 same cycle", gate, 8'h04);
        in1 = 1; #1 chk("R2 both pins", gate, 8'h0C);
        in0 = 0; in1 = 0;
        wr(3'd0, 8'h81); chk("R2 cmd after edge", gate, 8'h81);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_remap;
        wr(3'd1, 8'hF0); wr(3'd2, 8'h00);
        in0 = 1; in1 = 1; #1 chk("R3 one pin many channels", gate, 8'hF0);
        in0 = 0; #1 chk("R3 empty mask", gate, 8'h00);
        in1 = 0;
        wr(3'd1, 8'h04); wr(3'd2, 8'h08);
    endtask

    task automatic t_sleep;
        wr(3'd0, 8'hFF);
        sleep_n = 0; in0 = 1; in1 = 0; #1 chk("R4 sleep in0", gate, 8'h04);
        in0 = 0; in1 = 1; #1 chk("R4 sleep in1", gate, 8'h08);
        oc_evt = 8'h08; step(); oc_evt = 0;
        #1 chk("R4 bypass ignores fault", gate, 8'h08);
        wr(3'd3, 8'h08); in1 = 0; sleep_n = 1;
        wr(3'd0, 8'h00);
    endtask

    task automatic t_fault_clear;
        logic [7:0] d;
        wr(3'd0, 8'h30);
        oc_evt = 8'h10; step();
        chk("R5 oc trips", gate, 8'h20);
        wr(3'd3, 8'h10);
        rd(3'd6, d); chk("R6 clear blocked by live event", d, 8'h10);
        oc_evt = 0;
        wr(3'd3, 8'hEF);
        rd(3'd6, d); chk("R6 zero bit keeps latch", d, 8'h10);
        wr(3'd3, 8'h10);
        chk("R6 clear restores gate", gate, 8'h30);
        ot_evt = 8'h20; step(); ot_evt = 0;
        rd(3'd6, d); chk("R5/R8 ot latch readback", d, 8'h20);
        chk("R5 ot forces off", gate, 8'h10);
        step(3);
        chk("R7 no restart without limp", fault, 8'h20);
        wr(3'd3, 8'h20); wr(3'd0, 8'h00);
        rd(3'd7, d); chk("R8 unused address", d, 8'h00);
    endtask

    task automatic t_limp;
        wr(3'd4, 8'd5);
        limp = 1; in0 = 1;
        oc_evt = 8'h04; step(); oc_evt = 0;
        chk("R7 tripped", gate, 8'h00);
        step(3); in0 = 0; step(); in0 = 1;
        step(4); chk("R7 pin low restarted count", fault, 8'h04);
        step(); chk("R7 restart after count", fault, 8'h00);
        chk("R7 gate back on", gate, 8'h04);
        oc_evt = 8'h04; step(); oc_evt = 0;
        step(2); limp = 0; step(); limp = 1;
        step(4); chk("R7 limp exit restarted count", fault, 8'h04);
        step(); chk("R7 restart after re-entry", fault, 8'h00);
        wr(3'd4, 8'd0);
        oc_evt = 8'h04; step(); oc_evt = 0;
        chk("R9 latched", fault, 8'h04);
        step(); chk("R9 zero acts as one", fault, 8'h00);
        limp = 0; in0 = 0;
    endtask

    initial begin
        fork
            begin
                step(3); rst = 0; step();
                t_reset();
                t_default_map();
                t_remap();
                t_sleep();
                t_fault_clear();
                t_limp();
                done = 1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    total++; bad++;
                    $display("FAIL watchdog actual=hung expected=done");
                end
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule